// File: doc/BRIEF.md
# Limited-Slot Locality Classifier

This block decides, for one shared cache line, whether a requesting core should receive a private copy of the line or should be served by single-word accesses at the shared cache. It does not keep locality state for every core. It keeps a small fixed set of slots. Each slot holds a core number, a mode (private or remote) and a remote-use counter. A core that owns a slot follows a threshold policy. A remote core is promoted to private once its accesses at the shared cache reach the threshold. A private core is demoted to remote when the private-use count it reports on eviction or invalidation is below the threshold.

A core that has no slot receives the mode that most valid slots hold. A tie, or no valid slot at all, gives private. That core then takes a slot: the lowest free slot if there is one, otherwise the least recently requested slot. Requests and use reports come in on two separate input groups. The response mode and the promote or demote events leave one clock later from registers.

Top module: `lac_classifier`

## Requirements
- R1: While reset is held, and in the first cycle after it, `resp_valid`, `promote` and `demote` are 0. Reset empties every slot.
- R2: `resp_valid` is 1 in exactly the cycle after a cycle with `req_valid` high. `resp_private` (1 = private, 0 = remote) gives the mode chosen for that request.
- R3: A request from a core that has no slot is answered remote only if valid remote slots outnumber valid private slots. Otherwise it is answered private, which covers a tie and the case of no valid slot.
- R4: A request from a core without a slot fills the lowest-numbered empty slot with that core, the voted mode and a remote-use count of 0. An allocating request does not count as a remote use.
- R5: When every slot is valid, a request from a core without a slot replaces the slot whose last request is oldest. Reports do not change this age order.
- R6: A request from a tracked remote core raises its count by one. When the new count reaches PCT, the slot becomes private, its count is cleared and the response is private. In the cycle after the request, `promote` is 1 and `evt_core` carries the core number. Below PCT the response is remote.
- R7: A report from a tracked private core with `rpt_util` below PCT turns the slot remote and clears its count. In the cycle after the report, `demote` is 1 and `evt_core` carries the core number. A reported value of PCT or more changes nothing.
- R8: A request with `req_write` high clears the remote-use count of every other tracked remote slot.
- R9: A report is ignored in three cases: when `req_valid` is high in the same cycle, when the reporting core has no slot, and when the core's slot is remote.
- R10: A request from a tracked private core is answered private and leaves that slot unchanged.
- R11: `promote` and `demote` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request for the line |
| req_core | input | CID_W | Requesting core number |
| req_write | input | 1 | Request is a write |
| rpt_valid | input | 1 | Private-use report (eviction or invalidation) |
| rpt_core | input | CID_W | Reporting core number |
| rpt_util | input | UTIL_W | Reported private-use count |
| resp_valid | output | 1 | Response to the previous cycle's request |
| resp_private | output | 1 | 1 = hand out a private copy, 0 = remote word access |
| promote | output | 1 | A tracked core moved from remote to private |
| demote | output | 1 | A tracked core moved from private to remote |
| evt_core | output | CID_W | Core number for promote or demote |

## Verification
The hardest condition to produce is a full set of slots in which the age order is known, together with proof at the ports of which core was evicted. Every slot's mode looks the same from outside, so the eviction cannot be seen directly. The stimulus first fills all slots in a known request order and then requests a new core. It then sends a low use report to the core expected to be evicted, which must produce no demote. It also sends one to a core expected to survive, which must produce a demote. A second sequence makes remote slots the majority, so that a newly arriving core is answered remote and later promoted.

// File: rtl/lac_pkg.sv
// Shared types for the limited-slot locality classifier.
// Assumes: the mode encoding below is used on every slot.
package lac_pkg;
    typedef enum logic {
        MODE_PRIVATE = 1'b0,
        MODE_REMOTE  = 1'b1
    } lac_mode_e;
endpackage

// File: rtl/lac_match.sv
// Associative lookup: compares a core number against every slot in one
// cycle. Reports a hit and the lowest matching slot.
// Assumes: at most one valid slot holds a given core (the top keeps this).
module lac_match #(
    parameter int NUM_SLOTS = 3,
    parameter int CID_W     = 4,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [NUM_SLOTS-1:0]            slot_vld,
    input  logic [NUM_SLOTS-1:0][CID_W-1:0] slot_id,
    input  logic [CID_W-1:0]                key,
    output logic                            hit,
    output logic [IDX_W-1:0]                hit_idx
);
    // Scan from the top slot down so the lowest match wins.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (slot_vld[i] && slot_id[i] == key) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/lac_vote.sv
// Majority vote over the valid slots. The result is remote only when
// remote slots strictly outnumber private ones.
// Assumes: slot_rem is meaningful only where slot_vld is set.
module lac_vote #(
    parameter int NUM_SLOTS = 3,
    localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic [NUM_SLOTS-1:0] slot_vld,
    input  logic [NUM_SLOTS-1:0] slot_rem,
    output logic                 vote_remote
);
    logic [CNT_W-1:0] n_rem;
    logic [CNT_W-1:0] n_priv;

    // Count the valid slots of each mode and compare the two counts.
    always_comb begin
        n_rem  = '0;
        n_priv = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (slot_vld[i]) begin
                if (slot_rem[i]) n_rem  = n_rem  + 1'b1;
                else             n_priv = n_priv + 1'b1;
            end
        end
        vote_remote = (n_rem > n_priv);
    end
endmodule

// File: rtl/lac_lru.sv
// Slot allocator. Keeps a recency rank per slot (0 = newest) and names the
// slot a new core should take: the lowest empty slot if any, else the
// oldest slot.
// Assumes: touch_idx equals alloc_idx whenever touch_alloc is set.
module lac_lru #(
    parameter int NUM_SLOTS = 3,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] slot_vld,
    input  logic                 touch,
    input  logic [IDX_W-1:0]     touch_idx,
    input  logic                 touch_alloc,
    output logic [IDX_W-1:0]     alloc_idx
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(NUM_SLOTS - 1);

    logic [NUM_SLOTS-1:0][IDX_W-1:0] rank_q;
    logic                            has_free;
    logic [IDX_W-1:0]                free_idx;
    logic [IDX_W-1:0]                victim_idx;
    logic [IDX_W-1:0]                old_rank;

    // Find the lowest empty slot and the slot holding the oldest rank.
    always_comb begin
        has_free   = 1'b0;
        free_idx   = '0;
        victim_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (!slot_vld[i]) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (rank_q[i] == OLDEST) victim_idx = IDX_W'(i);
        end
        alloc_idx = has_free ? free_idx : victim_idx;
        old_rank  = touch_alloc ? OLDEST : rank_q[touch_idx];
    end

    // Move the touched slot to rank 0 and age the slots newer than it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rank_q <= '0;
        end else if (touch) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (IDX_W'(i) == touch_idx)
                    rank_q[i] <= '0;
                else if (slot_vld[i] && rank_q[i] < old_rank)
                    rank_q[i] <= rank_q[i] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lac_classifier.sv
// Limited-slot locality classifier for one shared line. Chooses private or
// remote mode per request, tracks a few cores in slots, votes for the others,
// and flags promote/demote transitions. Outputs are registered.
// Assumes: 1 <= PCT < 2**UTIL_W; one request and one report at most per cycle.
module lac_classifier
    import lac_pkg::*;
#(
    parameter int NUM_CORES = 16,
    parameter int NUM_SLOTS = 3,
    parameter int UTIL_W    = 3,
    parameter int PCT       = 3,
    localparam int CID_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CID_W-1:0]  req_core,
    input  logic              req_write,
    input  logic              rpt_valid,
    input  logic [CID_W-1:0]  rpt_core,
    input  logic [UTIL_W-1:0] rpt_util,
    output logic              resp_valid,
    output logic              resp_private,
    output logic              promote,
    output logic              demote,
    output logic [CID_W-1:0]  evt_core
);
    localparam logic [UTIL_W:0] THRESH = (UTIL_W + 1)'(PCT);

    logic [NUM_SLOTS-1:0]              vld_q, vld_d;
    logic [NUM_SLOTS-1:0][CID_W-1:0]   id_q, id_d;
    lac_mode_e                         mode_q [NUM_SLOTS];
    lac_mode_e                         mode_d [NUM_SLOTS];
    logic [NUM_SLOTS-1:0][UTIL_W-1:0]  util_q, util_d;
    logic [NUM_SLOTS-1:0]              rem_vec;

    logic             rq_hit, rp_hit, vote_remote;
    logic [IDX_W-1:0] rq_idx, rp_idx, alloc_idx, tgt;
    logic             touch, touch_alloc;
    logic             resp_d, priv_d, pro_d, dem_d;
    logic [CID_W-1:0] core_d;
    logic [UTIL_W:0]  bumped;

    // Expose each slot's mode as a plain remote bit for the voter.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_rem
        assign rem_vec[g] = (mode_q[g] == MODE_REMOTE);
    end

    lac_match #(.NUM_SLOTS(NUM_SLOTS), .CID_W(CID_W)) u_req_match (
        .slot_vld(vld_q), .slot_id(id_q), .key(req_core),
        .hit(rq_hit), .hit_idx(rq_idx)
    );

    lac_match #(.NUM_SLOTS(NUM_SLOTS), .CID_W(CID_W)) u_rpt_match (
        .slot_vld(vld_q), .slot_id(id_q), .key(rpt_core),
        .hit(rp_hit), .hit_idx(rp_idx)
    );

    lac_vote #(.NUM_SLOTS(NUM_SLOTS)) u_vote (
        .slot_vld(vld_q), .slot_rem(rem_vec), .vote_remote(vote_remote)
    );

    lac_lru #(.NUM_SLOTS(NUM_SLOTS)) u_lru (
        .clk(clk), .rst_n(rst_n), .slot_vld(vld_q),
        .touch(touch), .touch_idx(tgt), .touch_alloc(touch_alloc),
        .alloc_idx(alloc_idx)
    );

    // Decide the response and the next slot contents for this cycle.
    always_comb begin
        vld_d       = vld_q;
        id_d        = id_q;
        mode_d      = mode_q;
        util_d      = util_q;
        resp_d      = 1'b0;
        priv_d      = 1'b0;
        pro_d       = 1'b0;
        dem_d       = 1'b0;
        core_d      = evt_core;
        touch       = 1'b0;
        touch_alloc = 1'b0;
        tgt         = rq_hit ? rq_idx : alloc_idx;
        bumped      = {1'b0, util_q[rq_idx]} + 1'b1;
        if (req_valid) begin
            resp_d = 1'b1;
            touch  = 1'b1;
            if (rq_hit) begin
                if (mode_q[rq_idx] == MODE_REMOTE) begin
                    if (bumped >= THRESH) begin
                        mode_d[rq_idx] = MODE_PRIVATE;
                        util_d[rq_idx] = '0;
                        priv_d         = 1'b1;
                        pro_d          = 1'b1;
                        core_d         = req_core;
                    end else begin
                        util_d[rq_idx] = bumped[UTIL_W-1:0];
                    end
                end else begin
                    priv_d = 1'b1;
                end
            end else begin
                touch_alloc = 1'b1;
                vld_d[tgt]  = 1'b1;
                id_d[tgt]   = req_core;
                mode_d[tgt] = vote_remote ? MODE_REMOTE : MODE_PRIVATE;
                util_d[tgt] = '0;
                priv_d      = !vote_remote;
            end
            if (req_write) begin
                for (int i = 0; i < NUM_SLOTS; i++) begin
                    if (IDX_W'(i) != tgt && vld_q[i] && mode_q[i] == MODE_REMOTE)
                        util_d[i] = '0;
                end
            end
        end else if (rpt_valid && rp_hit && mode_q[rp_idx] == MODE_PRIVATE
                     && {1'b0, rpt_util} < THRESH) begin
            mode_d[rp_idx] = MODE_REMOTE;
            util_d[rp_idx] = '0;
            dem_d          = 1'b1;
            core_d         = rpt_core;
        end
    end

    // Hold the per-slot state.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[g]  <= 1'b0;
                id_q[g]   <= '0;
                mode_q[g] <= MODE_PRIVATE;
                util_q[g] <= '0;
            end else begin
                vld_q[g]  <= vld_d[g];
                id_q[g]   <= id_d[g];
                mode_q[g] <= mode_d[g];
                util_q[g] <= util_d[g];
            end
        end
    end

    // Register the response and the event outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid   <= 1'b0;
            resp_private <= 1'b0;
            promote      <= 1'b0;
            demote       <= 1'b0;
            evt_core     <= '0;
        end else begin
            resp_valid   <= resp_d;
            resp_private <= priv_d;
            promote      <= pro_d;
            demote       <= dem_d;
            evt_core     <= core_d;
        end
    end
endmodule

// File: rtl/lac_classifier_chk.sv
// Protocol checker for lac_classifier, attached by bind below.
// Assumes: the same PCT and UTIL_W as the checked instance.
module lac_classifier_chk #(
    parameter int UTIL_W = 3,
    parameter int PCT    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              rpt_valid,
    input logic [UTIL_W-1:0] rpt_util,
    input logic              resp_valid,
    input logic              resp_private,
    input logic              promote,
    input logic              demote
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!resp_valid && !promote && !demote));

    a_r2_resp_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    a_r2_no_resp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    a_r6_promote_private: assert property (@(posedge clk) disable iff (!rst_n)
        promote |-> (resp_valid && resp_private));

    a_r7_demote_low_util: assert property (@(posedge clk) disable iff (!rst_n)
        demote |-> ($past(rpt_valid) && ({1'b0, $past(rpt_util)} < (UTIL_W + 1)'(PCT))));

    a_r9_report_under_req: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && req_valid) |=> !demote);

    a_r11_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({promote, demote}));
endmodule

bind lac_classifier lac_classifier_chk #(.UTIL_W(UTIL_W), .PCT(PCT)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rpt_valid(rpt_valid),
    .rpt_util(rpt_util), .resp_valid(resp_valid), .resp_private(resp_private),
    .promote(promote), .demote(demote)
);

// File: tb/lac_classifier_tb.sv
module lac_classifier_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, rpt_valid = 1'b0;
    logic [3:0] req_core = '0, rpt_core = '0, evt_core;
    logic [2:0] rpt_util = '0;
    logic       resp_valid, resp_private, promote, demote;
    int         n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    lac_classifier u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
        .req_write(req_write), .rpt_valid(rpt_valid), .rpt_core(rpt_core),
        .rpt_util(rpt_util), .resp_valid(resp_valid), .resp_private(resp_private),
        .promote(promote), .demote(demote), .evt_core(evt_core)
    );

    typedef struct packed {
        logic       rpt;
        logic [3:0] core;
        logic       wr;
        logic [2:0] util;
        logic       e_rv;
        logic       e_priv;
        logic       e_pro;
        logic       e_dem;
    } vec_t;

    // PCT = 3, three slots. Comments give the requirement each step checks.
    localparam vec_t TABLE [19] = '{
        '{1'b0, 4'd1, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0}, // R3 empty -> private, R4 slot0
        '{1'b1, 4'd1, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 demote core1
        '{1'b0, 4'd1, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 count 1
        '{1'b0, 4'd1, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 count 2
        '{1'b0, 4'd2, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 remote majority, R8 clear core1
        '{1'b0, 4'd1, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R8 count restarted: 1
        '{1'b0, 4'd1, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R8 count 2
        '{1'b0, 4'd1, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0}, // R6 promote core1
        '{1'b0, 4'd3, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0}, // R3 tie -> private
        '{1'b1, 4'd3, 1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 high report, no change
        '{1'b0, 4'd3, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0}, // R10 tracked private
        '{1'b0, 4'd4, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0}, // R5 evict core2
        '{1'b0, 4'd2, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0}, // R5 evict core1
        '{1'b1, 4'd1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 R9 core1 gone: ignored
        '{1'b1, 4'd3, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 core3 kept: demote
        '{1'b0, 4'd4, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0}, // R10 core4 kept private
        '{1'b0, 4'd7, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0}, // R3 2 private vs 1 -> private
        '{1'b1, 4'd7, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 core7 tracked private
        '{1'b1, 4'd7, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0}  // R9 remote slot ignores report
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic rq, input logic [3:0] rc, input logic wr,
                         input logic rp, input logic [3:0] pc, input logic [2:0] pu);
        @(negedge clk);
        req_valid = rq; req_core = rc; req_write = wr;
        rpt_valid = rp; rpt_core = pc; rpt_util = pu;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 4'd0, 1'b0, 1'b0, 4'd0, 3'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0; rpt_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        chk("R1 resp_valid in reset", int'(resp_valid), 0);
        chk("R1 promote in reset", int'(promote), 0);
        chk("R1 demote in reset", int'(demote), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        for (int i = 0; i < 19; i++) begin
            vec_t v;
            v = TABLE[i];
            drive(!v.rpt, v.core, v.wr, v.rpt, v.core, v.util);
            chk($sformatf("R2 resp_valid step %0d", i), int'(resp_valid), int'(v.e_rv));
            if (v.e_rv)
                chk($sformatf("R3 R6 resp_private step %0d", i), int'(resp_private), int'(v.e_priv));
            chk($sformatf("R6 promote step %0d", i), int'(promote), int'(v.e_pro));
            chk($sformatf("R7 demote step %0d", i), int'(demote), int'(v.e_dem));
            if (v.e_pro || v.e_dem)
                chk($sformatf("R6 R7 evt_core step %0d", i), int'(evt_core), int'(v.core));
            chk("R11 events exclusive", int'(promote && demote), 0);
        end
        idle();
        chk("R2 no response when idle", int'(resp_valid), 0);

        // Remote majority, then promotion of a newly allocated remote core.
        do_reset();
        drive(1'b1, 4'd1, 1'b0, 1'b0, 4'd0, 3'd0);
        chk("R1 slots empty after reset: private", int'(resp_private), 1);
        drive(1'b0, 4'd0, 1'b0, 1'b1, 4'd1, 3'd0);
        drive(1'b1, 4'd2, 1'b0, 1'b0, 4'd0, 3'd0);
        chk("R3 one remote slot -> remote", int'(resp_private), 0);
        drive(1'b1, 4'd3, 1'b0, 1'b0, 4'd0, 3'd0);
        chk("R3 two remote slots -> remote", int'(resp_private), 0);
        drive(1'b1, 4'd3, 1'b0, 1'b0, 4'd0, 3'd0);
        chk("R4 alloc not counted: first use remote", int'(resp_private), 0);
        drive(1'b1, 4'd3, 1'b0, 1'b0, 4'd0, 3'd0);
        chk("R4 second use remote", int'(promote), 0);
        drive(1'b1, 4'd3, 1'b0, 1'b0, 4'd0, 3'd0);
        chk("R6 third use promotes", int'(promote), 1);
        chk("R6 promoted core", int'(evt_core), 3);

        // Report in the same cycle as a request is dropped.
        do_reset();
        drive(1'b1, 4'd5, 1'b0, 1'b0, 4'd0, 3'd0);
        drive(1'b1, 4'd6, 1'b0, 1'b1, 4'd5, 3'd0);
        chk("R9 coincident report: no demote", int'(demote), 0);
        chk("R3 private majority for core6", int'(resp_private), 1);
        drive(1'b1, 4'd5, 1'b0, 1'b0, 4'd0, 3'd0);
        chk("R9 core5 still private", int'(resp_private), 1);
        drive(1'b0, 4'd0, 1'b0, 1'b1, 4'd5, 3'd2);
        chk("R7 later report demotes core5", int'(demote), 1);
        idle();
        chk("R7 demote is one cycle", int'(demote), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule